// File: doc/BRIEF.md
# Per-Lane Write Leveling Engine

This block calibrates the outgoing data strobe of every byte lane on a fly-by memory bus. In a fly-by layout the memory clock reaches each device at a different time, so each lane needs its own strobe delay. For each lane the engine drives a delay tap value to an external programmable delay line. It requests leveling strobe pulses and reads back one feedback bit per lane. That bit is the memory clock level that the device captured on the strobe edge.

After a start pulse, all lanes sweep in parallel. Every lane begins at tap 0 and moves up one tap per measurement step. A lane stops as soon as its feedback reads 0 at one tap and 1 at the next, and it then keeps that tap. A lane that reaches the top tap without finding that change is marked failed and keeps the top tap. Each step is timed by two programmable counts. The settle count covers the time the delay line needs after a tap change. The sample latency covers the time between the strobe pulse and valid feedback. When every lane has locked or failed, the engine pulses done and holds all results until the next start.

Top module: `wlvl_engine`

## Requirements
- R1: While reset is asserted and after it is released: every lane tap is 0, every locked and failed flag is 0, and busy, done and dqs_pulse are all 0.
- R2: A lane tap changes only in two ways: it moves up by exactly one as the result of a feedback sample, or it returns to 0 when a start is accepted. A tap is never skipped.
- R3: A lane locks at tap i (i >= 1) when its feedback sampled at tap i-1 was 0 and its feedback sampled at tap i is 1. The lane's locked flag then sets and its tap holds at i.
- R4: A feedback of 1 that is not preceded by a 0 at the previous tap does not lock the lane. This includes a 1 seen at tap 0 and a run of leading 1s. The sweep continues until a 0 followed by a 1 is seen.
- R5: A lane that samples the top tap (all ones, 63 by default) without a lock sets its failed flag and keeps the top tap. Locked and failed are never both set.
- R6: Each lane resolves from its own feedback bit only. Lanes with different feedback patterns end at different taps within one run.
- R7: Each measurement step emits one dqs_pulse that lasts one cycle. Consecutive pulses in a run are exactly settle_cyc + sample_lat + 5 cycles apart. The number of pulses in a run equals the largest number of taps sampled by any lane.
- R8: done is high for exactly one cycle, only once every lane is locked or failed. busy is low from the next cycle on. Taps and flags stay unchanged until the next accepted start.
- R9: A start while busy is high is ignored. The running sweep, its pulse count and its results are unchanged.
- R10: A start accepted while idle clears all flags and sets all taps to 0 one cycle later, with busy high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a leveling run (accepted only when idle) |
| settle_cyc | input | CNT_W | Extra wait cycles after a tap change before the pulse |
| sample_lat | input | CNT_W | Extra wait cycles between pulse and feedback sample |
| lvl_fb | input | LANES | Per-lane sampled memory clock level |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse when all lanes are resolved |
| dqs_pulse | output | 1 | Request for one leveling strobe pulse |
| lane_tap | output | LANES*TAP_W | Per-lane delay tap, lane n in bits [n*TAP_W +: TAP_W] |
| lane_locked | output | LANES | Lane found its 0-to-1 change |
| lane_failed | output | LANES | Lane reached top tap without a change |

## Verification
The hardest case to reach from the ports is a run where lanes finish at very different times. Early lanes must stay frozen through dozens of later steps, and done must wait for the last lane. It is harder still when that last lane fails at the top tap or locks exactly on it. The bench makes the feedback a function of each lane's own current tap output through a per-lane pattern table. One table run mixes a clean edge, leading ones, an edge at tap 1, a glitchy pattern, an edge only at the top tap, and the two constant patterns. A start is injected halfway through that run to show it is ignored.

// File: rtl/wlvl_pkg.sv
package wlvl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETTLE,
    PH_PULSE,
    PH_WAIT,
    PH_SAMPLE,
    PH_CHECK
  } phase_e;

  typedef enum logic [1:0] {
    ACT_STEP,
    ACT_LOCK,
    ACT_FAIL
  } lane_act_e;

  // Decision for one lane at a feedback sample.
  function automatic lane_act_e lane_decide(input logic fb, input logic prev_low,
                                            input logic at_max);
    if (fb && prev_low)
      return ACT_LOCK;
    else if (at_max)
      return ACT_FAIL;
    else
      return ACT_STEP;
  endfunction

  // Wait counter has reached its programmed limit.
  function automatic logic count_reached(input int unsigned cnt, input int unsigned lim);
    return cnt >= lim;
  endfunction

endpackage

// File: rtl/wlvl_seq.sv
module wlvl_seq
  import wlvl_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] settle_cyc,
  input  logic [CNT_W-1:0] sample_lat,
  input  logic             all_resolved,
  output logic             start_go,
  output logic             dqs_pulse,
  output logic             sample_now,
  output logic             done,
  output logic             busy
);

  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic             settle_end;
  logic             wait_end;

  assign settle_end = count_reached(32'(cnt_q), 32'(settle_cyc));
  assign wait_end   = count_reached(32'(cnt_q), 32'(sample_lat));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          if (start) begin
            phase_q <= PH_SETTLE;
            cnt_q   <= '0;
          end
        end
        PH_SETTLE: begin
          if (settle_end) begin
            phase_q <= PH_PULSE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_PULSE: begin
          phase_q <= PH_WAIT;
          cnt_q   <= '0;
        end
        PH_WAIT: begin
          if (wait_end) phase_q <= PH_SAMPLE;
          else          cnt_q   <= cnt_q + 1'b1;
        end
        PH_SAMPLE: phase_q <= PH_CHECK;
        PH_CHECK: begin
          if (all_resolved) begin
            phase_q <= PH_IDLE;
          end else begin
            phase_q <= PH_SETTLE;
            cnt_q   <= '0;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign start_go   = start && (phase_q == PH_IDLE);
  assign dqs_pulse  = (phase_q == PH_PULSE);
  assign sample_now = (phase_q == PH_SAMPLE);
  assign done       = (phase_q == PH_CHECK) && all_resolved;
  assign busy       = (phase_q != PH_IDLE);

endmodule

// File: rtl/wlvl_lane.sv
module wlvl_lane
  import wlvl_pkg::*;
#(
  parameter int TAP_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             sample,
  input  logic             fb,
  output logic [TAP_W-1:0] tap,
  output logic             locked,
  output logic             failed
);

  localparam logic [TAP_W-1:0] TAP_MAX = {TAP_W{1'b1}};

  logic [TAP_W-1:0] tap_q;
  logic             prev_low_q;
  logic             locked_q;
  logic             failed_q;
  logic             active;
  lane_act_e        act;

  assign active = !locked_q && !failed_q;
  assign act    = lane_decide(fb, prev_low_q, tap_q == TAP_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      tap_q      <= '0;
      prev_low_q <= 1'b0;
      locked_q   <= 1'b0;
      failed_q   <= 1'b0;
    end else if (sample && active) begin
      prev_low_q <= !fb;
      case (act)
        ACT_LOCK: locked_q <= 1'b1;
        ACT_FAIL: failed_q <= 1'b1;
        default:  tap_q    <= tap_q + 1'b1;
      endcase
    end
  end

  assign tap    = tap_q;
  assign locked = locked_q;
  assign failed = failed_q;

endmodule

// File: rtl/wlvl_engine.sv
module wlvl_engine #(
  parameter int LANES = 8,
  parameter int TAP_W = 6,
  parameter int CNT_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [CNT_W-1:0]       settle_cyc,
  input  logic [CNT_W-1:0]       sample_lat,
  input  logic [LANES-1:0]       lvl_fb,
  output logic                   busy,
  output logic                   done,
  output logic                   dqs_pulse,
  output logic [LANES*TAP_W-1:0] lane_tap,
  output logic [LANES-1:0]       lane_locked,
  output logic [LANES-1:0]       lane_failed
);

  // internal events, visible to the bound checker
  logic start_go;
  logic sample_now;
  logic all_resolved;

  assign all_resolved = &(lane_locked | lane_failed);

  wlvl_seq #(.CNT_W(CNT_W)) seq_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .settle_cyc  (settle_cyc),
    .sample_lat  (sample_lat),
    .all_resolved(all_resolved),
    .start_go    (start_go),
    .dqs_pulse   (dqs_pulse),
    .sample_now  (sample_now),
    .done        (done),
    .busy        (busy)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    wlvl_lane #(.TAP_W(TAP_W)) lane_i (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (start_go),
      .sample(sample_now),
      .fb    (lvl_fb[g]),
      .tap   (lane_tap[g*TAP_W +: TAP_W]),
      .locked(lane_locked[g]),
      .failed(lane_failed[g])
    );
  end

endmodule

// File: rtl/wlvl_engine_chk.sv
module wlvl_engine_chk #(
  parameter int LANES = 8,
  parameter int TAP_W = 6
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   start_go,
  input logic                   sample_now,
  input logic                   busy,
  input logic                   done,
  input logic                   dqs_pulse,
  input logic [LANES*TAP_W-1:0] lane_tap,
  input logic [LANES-1:0]       lane_locked,
  input logic [LANES-1:0]       lane_failed
);

  localparam logic [TAP_W-1:0] TOP = {TAP_W{1'b1}};

  p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dqs_pulse |=> !dqs_pulse);

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  p_done_resolved_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> &(lane_locked | lane_failed));

  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_go |=> busy && lane_tap == '0 && lane_locked == '0 && lane_failed == '0);

  for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
    p_tap_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(lane_tap[g*TAP_W +: TAP_W]) |->
        (($past(sample_now) && lane_tap[g*TAP_W +: TAP_W] ==
           $past(lane_tap[g*TAP_W +: TAP_W]) + 1'b1) ||
         ($past(start_go) && lane_tap[g*TAP_W +: TAP_W] == '0)));

    p_lock_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      lane_locked[g] && !start_go |=> lane_locked[g] && $stable(lane_tap[g*TAP_W +: TAP_W]));

    p_fail_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
      lane_failed[g] |-> lane_tap[g*TAP_W +: TAP_W] == TOP && !lane_locked[g]);

    p_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !start_go && (lane_locked[g] || lane_failed[g]) |=>
        lane_locked[g] || lane_failed[g]);
  end

endmodule

bind wlvl_engine wlvl_engine_chk #(.LANES(LANES), .TAP_W(TAP_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_go   (start_go),
  .sample_now (sample_now),
  .busy       (busy),
  .done       (done),
  .dqs_pulse  (dqs_pulse),
  .lane_tap   (lane_tap),
  .lane_locked(lane_locked),
  .lane_failed(lane_failed)
);

// File: tb/wlvl_engine_tb_top.sv
module wlvl_engine_tb_top;

  localparam int LANES = 8;
  localparam int TAP_W = 6;
  localparam int CNT_W = 8;
  localparam int NT    = 1 << TAP_W;

  typedef struct {
    int lane;
    int tap;
    bit lk;
    bit fl;
  } exp_t;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic                   start = 1'b0;
  logic [CNT_W-1:0]       settle_cyc = '0;
  logic [CNT_W-1:0]       sample_lat = '0;
  logic [LANES-1:0]       lvl_fb;
  logic                   busy, done, dqs_pulse;
  logic [LANES*TAP_W-1:0] lane_tap;
  logic [LANES-1:0]       lane_locked, lane_failed;

  logic [NT-1:0] pat [LANES];
  exp_t          sb_q [$];
  int            exp_tap [LANES];
  int            nchk = 0, nerr = 0, cyc = 0;
  int            pulses = 0, last_pulse = -1, period = 0;
  bit            done_seen = 0;
  int            prev_tap [LANES];

  always #5 clk = ~clk;

  wlvl_engine #(.LANES(LANES), .TAP_W(TAP_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .settle_cyc(settle_cyc),
    .sample_lat(sample_lat), .lvl_fb(lvl_fb), .busy(busy), .done(done),
    .dqs_pulse(dqs_pulse), .lane_tap(lane_tap), .lane_locked(lane_locked),
    .lane_failed(lane_failed)
  );

  // memory model: feedback is the lane's pattern at its current tap
  always_comb begin
    for (int l = 0; l < LANES; l++) lvl_fb[l] = pat[l][lane_tap[l*TAP_W +: TAP_W]];
  end

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int find_edge(input logic [NT-1:0] p);
    for (int i = 1; i < NT; i++) if (!p[i-1] && p[i]) return i;
    return -1;
  endfunction

  function automatic int tap_of(input int l);
    return int'(lane_tap[l*TAP_W +: TAP_W]);
  endfunction

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nerr++; nchk++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  // monitor: pulse spacing, tap stepping, scoreboard at done
  always @(negedge clk) begin
    if (rst_n) begin
      if (dqs_pulse) begin
        if (last_pulse >= 0) chk("R7 pulse spacing", cyc - last_pulse, period);
        last_pulse = cyc;
        pulses++;
      end
      for (int l = 0; l < LANES; l++) begin
        if (tap_of(l) != prev_tap[l] && tap_of(l) != 0)
          chk("R2 tap step", tap_of(l), prev_tap[l] + 1);
        prev_tap[l] = tap_of(l);
      end
      if (done) begin
        done_seen = 1;
        for (int l = 0; l < LANES; l++) begin
          exp_t e;
          if (sb_q.size() == 0) begin
            chk("R8 scoreboard empty at done", 0, 1);
          end else begin
            e = sb_q.pop_front();
            chk($sformatf("R6/R3 lane %0d tap", e.lane), tap_of(e.lane), e.tap);
            chk($sformatf("R3/R4 lane %0d locked", e.lane), int'(lane_locked[e.lane]), int'(e.lk));
            chk($sformatf("R5 lane %0d failed", e.lane), int'(lane_failed[e.lane]), int'(e.fl));
          end
        end
      end
    end
  end

  // driver: push expectations, run one sweep, check the aftermath
  task automatic run(input int s, input int lat, input bit poke);
    int max_steps = 0;
    for (int l = 0; l < LANES; l++) begin
      exp_t e;
      int   k = find_edge(pat[l]);
      e.lane = l;
      e.lk   = (k >= 0);
      e.fl   = (k < 0);
      e.tap  = (k >= 0) ? k : NT - 1;
      exp_tap[l] = e.tap;
      if (e.tap + 1 > max_steps) max_steps = e.tap + 1;
      sb_q.push_back(e);
    end
    settle_cyc = CNT_W'(s);
    sample_lat = CNT_W'(lat);
    period     = s + lat + 5;
    pulses     = 0;
    last_pulse = -1;
    done_seen  = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk("R10 busy after start", int'(busy), 1);
    chk("R10 taps cleared", int'(lane_tap == '0), 1);
    chk("R10 flags cleared", int'(lane_locked | lane_failed), 0);
    if (poke) begin
      repeat (100) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    do @(negedge clk); while (!done_seen);
    @(negedge clk);
    chk("R8 done one cycle", int'(done), 0);
    chk("R8 busy low after done", int'(busy), 0);
    chk(poke ? "R9 pulse count with ignored start" : "R7 pulse count", pulses, max_steps);
    repeat (20) @(negedge clk);
    for (int l = 0; l < LANES; l++)
      chk($sformatf("R8 lane %0d tap held", l), tap_of(l), exp_tap[l]);
  endtask

  initial begin
    for (int l = 0; l < LANES; l++) begin pat[l] = '0; prev_tap[l] = 0; end
    repeat (3) @(negedge clk);
    chk("R1 reset taps", int'(lane_tap == '0), 1);
    chk("R1 reset outputs", int'({busy, done, dqs_pulse}), 0);
    chk("R1 reset flags", int'(lane_locked | lane_failed), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", int'({busy, done, dqs_pulse}), 0);

    // run A: mixed lanes, start poked mid-run
    for (int i = 0; i < NT; i++) begin
      pat[0][i] = (i >= 5);
      pat[1][i] = (i < 4) || (i >= 10);
      pat[2][i] = 1'b0;
      pat[3][i] = (i == NT - 1);
      pat[4][i] = 1'b1;
      pat[5][i] = (i >= 1);
      pat[6][i] = (i == 1);
      pat[7][i] = (i == 0) || (i >= 3);
    end
    run(2, 1, 1'b1);

    // run B: zero waits, staggered edges
    for (int l = 0; l < LANES; l++)
      for (int i = 0; i < NT; i++) pat[l][i] = (i >= l + 2);
    run(0, 0, 1'b0);

    // run C: long waits, leading one then edge at 2
    for (int l = 0; l < LANES; l++)
      for (int i = 0; i < NT; i++) pat[l][i] = (i != 1);
    run(7, 3, 1'b0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule